// File: doc/BRIEF.md
# Clock Prescaler Search Engine

This block works out the setting of a two-stage serial clock prescaler. Given a reference clock frequency and a requested serial rate, both 32-bit unsigned numbers in hertz, it tries every divisor of the form `factor * 2^exp`, with factor 1..15 and exp 0..7. It returns the setting whose integer output rate is the highest one that does not exceed the request.

A one-cycle `start_i` pulse latches both inputs and begins the search. The block visits the factors in the outer loop and the exponents in the inner loop. For each candidate it computes the rate as `ref >> exp` divided by the factor, using a restoring divider that retires a fixed number of quotient bits per cycle. It stops at once on an exact match. When the search ends, `done_o` pulses for one cycle. The packed configuration byte and the error flag then stay on their outputs until the next search.

An error means no setting can be used. This happens when every candidate rate overshoots the request, or when the request equals the reference clock. In the second case the block does not run the search at all.

Top module: `clk_prescale_search`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `err_o` are 0 and `cfg_o` is 0x00.
- R2: The rate of candidate (f, e) is floor(ref / (f * 2^e)). Candidates are visited with f ascending 1..15 in the outer loop and e ascending 0..7 in the inner loop. The first candidate whose rate equals the request is chosen, and the search ends there.
- R3: A candidate whose rate is above the request is never chosen. On a result with `err_o`=0, the rate of the chosen setting is at most the request.
- R4: With no exact match, the chosen candidate is the one with the smallest shortfall (request minus rate). The shortfall starts at 0xFFFFFFFF and a candidate replaces the best only when it is strictly smaller, so the earliest candidate wins a tie.
- R5: If no candidate qualifies, the result has `err_o`=1 and `cfg_o`=0x00.
- R6: If the request equals the reference on a start, `done_o` is 1 in the next cycle, with `err_o`=1 and `cfg_o`=0x00. No search is run.
- R7: The layout of `cfg_o` is: factor in bits [3:0], exponent bit 0 in bit 4, exponent bits [2:1] in bits [7:6], and bit 5 always 0.
- R8: `done_o` is high for exactly one cycle per start, and never while `busy_o` is high. `cfg_o` and `err_o` do not change unless a result is delivered.
- R9: A start while `busy_o` is high is ignored. The running search completes with its original inputs.
- R10: `done_o` rises no later than 1324 cycles after the start cycle, which is 120 candidates times 11 cycles plus 4, at the default 4 quotient bits per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that latches the inputs and begins a search |
| ref_hz_i | input | 32 | Reference clock frequency |
| want_hz_i | input | 32 | Requested serial rate |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| cfg_o | output | 8 | Packed factor and exponent |
| err_o | output | 1 | No usable setting |

## Verification
The assertions assume that `start_i` is a single-cycle pulse and that `ref_hz_i` and `want_hz_i` are valid in the start cycle. They do not assume that the inputs stay stable afterwards. The bench drives each start for exactly one cycle. It changes the inputs freely while a search is running, and it also issues an extra start during a search. Random requests are derived from the reference by shifts and divisions, so they cover exact matches, ordinary shortfalls and out-of-range cases.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  localparam int DATA_W    = 32;
  localparam int FACT_MAX  = 15;
  localparam int EXP_MAX   = 7;
  localparam int BPC       = 4;
  localparam int FW        = $clog2(FACT_MAX + 1);
  localparam int EW        = $clog2(EXP_MAX + 1);
  localparam int STEPS     = DATA_W / BPC;
  localparam int CAND_CYC  = STEPS + 3;
  localparam int MAX_LAT   = FACT_MAX * (EXP_MAX + 1) * CAND_CYC + 4;

  typedef enum logic {ST_IDLE, ST_RUN} ctl_state_e;

  function automatic logic [7:0] pack_cfg(logic [FW-1:0] f, logic [EW-1:0] e);
    pack_cfg = {e[2:1], 1'b0, e[0], f[3:0]};
  endfunction
endpackage

// File: rtl/presc_divider.sv
module presc_divider #(
  parameter int W   = 32,
  parameter int FW  = 4,
  parameter int BPC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [W-1:0]  dividend_i,
  input  logic [FW-1:0] divisor_i,
  output logic [W-1:0]  quot_o,
  output logic          fin_o
);
  localparam int STEPS = W / BPC;
  localparam int CW    = $clog2(STEPS + 1);

  logic [W-1:0]  acc_q, acc_d;
  logic [FW-1:0] rem_q, rem_d;
  logic [CW-1:0] cnt_q;
  logic          fin_q;

  // BPC restoring steps per cycle; remainder stays below divisor
  always_comb begin
    logic [FW:0] t;
    acc_d = acc_q;
    rem_d = rem_q;
    for (int k = 0; k < BPC; k++) begin
      t = {rem_d, acc_d[W-1]};
      if (t >= {1'b0, divisor_i}) begin
        t     = t - {1'b0, divisor_i};
        acc_d = {acc_d[W-2:0], 1'b1};
      end else begin
        acc_d = {acc_d[W-2:0], 1'b0};
      end
      rem_d = t[FW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else if (go_i) begin
      acc_q <= dividend_i;
      rem_q <= '0;
      cnt_q <= CW'(STEPS);
      fin_q <= 1'b0;
    end else if (cnt_q != '0) begin
      acc_q <= acc_d;
      rem_q <= rem_d;
      cnt_q <= cnt_q - CW'(1);
      fin_q <= (cnt_q == CW'(1));
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign quot_o = acc_q;
  assign fin_o  = fin_q;
endmodule

// File: rtl/presc_search_ctl.sv
module presc_search_ctl
  import prescale_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  ref_i,
  input  logic [W-1:0]  want_i,
  input  logic [W-1:0]  quot_i,
  input  logic          fin_i,
  output logic          go_o,
  output logic [W-1:0]  dividend_o,
  output logic [FW-1:0] factor_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [7:0]    cfg_o,
  output logic          err_o
);
  ctl_state_e    state_q;
  logic [W-1:0]  ref_q, want_q, best_s_q;
  logic [FW-1:0] fac_q, best_f_q;
  logic [EW-1:0] exp_q, best_e_q;
  logic          go_q, done_q, err_q;
  logic [7:0]    cfg_q;

  logic          over, hit, better, last;
  logic [W-1:0]  short, nb_s;
  logic [FW-1:0] nb_f;
  logic [EW-1:0] nb_e;

  always_comb begin
    over   = quot_i > want_q;
    hit    = quot_i == want_q;
    short  = want_q - quot_i;
    better = !over && !hit && (short < best_s_q);
    nb_f   = (hit || better) ? fac_q : best_f_q;
    nb_e   = (hit || better) ? exp_q : best_e_q;
    nb_s   = better ? short : best_s_q;
    last   = (fac_q == FW'(FACT_MAX)) && (exp_q == EW'(EXP_MAX));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ref_q    <= '0;
      want_q   <= '0;
      best_s_q <= '1;
      fac_q    <= '0;
      exp_q    <= '0;
      best_f_q <= '0;
      best_e_q <= '0;
      go_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      cfg_q    <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          ref_q  <= ref_i;
          want_q <= want_i;
          if (ref_i == want_i) begin
            cfg_q  <= '0;
            err_q  <= 1'b1;
            done_q <= 1'b1;
          end else begin
            fac_q    <= FW'(1);
            exp_q    <= '0;
            best_f_q <= '0;
            best_e_q <= '0;
            best_s_q <= '1;
            go_q     <= 1'b1;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: if (fin_i) begin
          if (hit || last) begin
            cfg_q   <= pack_cfg(nb_f, nb_e);
            err_q   <= (nb_f == '0);
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            best_f_q <= nb_f;
            best_e_q <= nb_e;
            best_s_q <= nb_s;
            if (exp_q == EW'(EXP_MAX)) begin
              exp_q <= '0;
              fac_q <= fac_q + FW'(1);
            end else begin
              exp_q <= exp_q + EW'(1);
            end
            go_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign go_o       = go_q;
  assign dividend_o = ref_q >> exp_q;
  assign factor_o   = fac_q;
  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = done_q;
  assign cfg_o      = cfg_q;
  assign err_o      = err_q;
endmodule

// File: rtl/clk_prescale_search.sv
module clk_prescale_search
  import prescale_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] ref_hz_i,
  input  logic [DATA_W-1:0] want_hz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        cfg_o,
  output logic              err_o
);
  logic              go;
  logic              fin;
  logic [DATA_W-1:0] dividend, quot;
  logic [FW-1:0]     factor;

  presc_search_ctl #(.W(DATA_W)) u_ctl (
    .clk_i, .rst_ni, .start_i,
    .ref_i(ref_hz_i), .want_i(want_hz_i),
    .quot_i(quot), .fin_i(fin),
    .go_o(go), .dividend_o(dividend), .factor_o(factor),
    .busy_o, .done_o, .cfg_o, .err_o
  );

  presc_divider #(.W(DATA_W), .FW(FW), .BPC(BPC)) u_div (
    .clk_i, .rst_ni, .go_i(go),
    .dividend_i(dividend), .divisor_i(factor),
    .quot_o(quot), .fin_o(fin)
  );
endmodule

// File: rtl/clk_prescale_search_chk.sv
module clk_prescale_search_chk
  import prescale_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DATA_W-1:0] ref_hz_i,
  input logic [DATA_W-1:0] want_hz_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [7:0]        cfg_o,
  input logic              err_o
);
  logic [15:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else if (busy_o) lat_q <= lat_q + 16'd1;
    else lat_q <= '0;
  end

  assert_lat_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q <= 16'(MAX_LAT));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !busy_o) |=> ($stable(cfg_o) && $stable(err_o)));

  assert_err_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (cfg_o == 8'h00));

  assert_ok_factor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (cfg_o[3:0] != 4'h0));

  assert_equal_fast_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (ref_hz_i == want_hz_i)) |=> (done_o && err_o));

  always_comb if (rst_ni) assert_bit5_R7: assert (cfg_o[5] == 1'b0);
endmodule

bind clk_prescale_search clk_prescale_search_chk u_chk (.*);

// File: tb/clk_prescale_search_bench.sv
module clk_prescale_search_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] ref_hz_i = '0, want_hz_i = '0;
  logic        busy_o, done_o, err_o;
  logic [7:0]  cfg_o;

  int n_chk = 0, n_fail = 0;
  bit dog = 1'b0;

  clk_prescale_search u_clk_prescale_search (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    #(10 * 190000);
    dog = 1'b1;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired (R10) actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic logic [8:0] model(logic [31:0] r, logic [31:0] w);
    logic [31:0] bs, rate;
    logic [3:0]  bf;
    logic [2:0]  be;
    if (r == w) return 9'h100;
    bs = '1; bf = 0; be = 0;
    for (int f = 1; f <= 15; f++) begin
      for (int e = 0; e <= 7; e++) begin
        rate = r / (32'(f) << e);
        if (rate > w) continue;
        if (rate == w) return {1'b0, 3'(e) >> 1 == 0 ? 2'b00 : 2'(3'(e) >> 1), 1'b0, 1'(e), 4'(f)};
        if (w - rate < bs) begin bs = w - rate; bf = 4'(f); be = 3'(e); end
      end
    end
    return {bf == 0, be[2:1], 1'b0, be[0], bf};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(logic [31:0] r, logic [31:0] w);
    @(negedge clk_i);
    ref_hz_i = r; want_hz_i = w; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done_o) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic run(logic [31:0] r, logic [31:0] w, string req);
    logic [8:0] e;
    int lat;
    logic [31:0] rate;
    e = model(r, w);
    pulse_start(r, w);
    wait_done(lat);
    chk({err_o, cfg_o} == e, req, {23'd0, err_o, cfg_o}, {23'd0, e});
    chk(lat <= 1324, "R10 latency", lat, 1324);
    if (!err_o) begin
      rate = r / ({28'd0, cfg_o[3:0]} << {cfg_o[7:6], cfg_o[4]});
      chk(rate <= w, "R3 no overshoot", rate, w);
    end
    @(negedge clk_i);
    chk(!done_o, "R8 done one cycle", {31'd0, done_o}, 0);
  endtask

  initial begin
    logic [31:0] r, w;
    logic [8:0]  e;
    int lat;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !err_o && cfg_o == 0, "R1 reset state",
        {busy_o, done_o, err_o, cfg_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && cfg_o == 0, "R1 idle after reset", {busy_o, done_o, cfg_o}, 0);

    // R6: equal request flagged in the next cycle
    pulse_start(32'd50_000_000, 32'd50_000_000);
    chk(done_o && err_o && cfg_o == 0 && !busy_o, "R6 equal request",
        {busy_o, done_o, err_o, cfg_o}, {2'b01, 1'b1, 8'h00});
    @(negedge clk_i);

    // R2/R7: exact hit f=1 e=2 -> cfg 0x41
    run(32'd200_000_000, 32'd50_000_000, "R2 exact hit");
    chk(cfg_o == 8'h41, "R7 packing f1e2", cfg_o, 8'h41);
    // R7: f=3 e=5 -> e[0]=1 bit4, e[2:1]=2 -> 0x93
    run(32'd96_000_000, 32'd1_000_000, "R7 exact f3e5");
    chk(cfg_o == 8'h93, "R7 packing f3e5", cfg_o, 8'h93);
    // R5: every candidate overshoots
    run(32'd1_000_000_000, 32'd1, "R5 out of range");
    chk(err_o && cfg_o == 0, "R5 err flag", {err_o, cfg_o}, 9'h100);
    // R4: shortfall selection, request above reference
    run(32'd1000, 32'd5000, "R4 best is f1e0");
    chk(cfg_o == 8'h01, "R4 first candidate", cfg_o, 8'h01);
    run(32'd250_000_000, 32'd20_000_000, "R4 shortfall");
    run(32'd0, 32'd3, "R4 zero reference");
    run(32'hFFFF_FFFF, 32'h0000_0000, "R2 zero request");
    run(32'hFFFF_FFFF, 32'h7FFF_FFFF, "R4 near full scale");

    // R9: start during a search is ignored
    e = model(32'd250_000_000, 32'd7_000_000);
    pulse_start(32'd250_000_000, 32'd7_000_000);
    repeat (20) @(negedge clk_i);
    chk(busy_o, "R8 busy during search", {31'd0, busy_o}, 1);
    ref_hz_i = 32'd400; want_hz_i = 32'd400; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!done_o, "R9 no early done", {31'd0, done_o}, 0);
    wait_done(lat);
    chk({err_o, cfg_o} == e, "R9 busy start ignored", {23'd0, err_o, cfg_o}, {23'd0, e});
    @(negedge clk_i);
    repeat (5) @(negedge clk_i);
    chk({err_o, cfg_o} == e && !done_o, "R8 result held", {23'd0, err_o, cfg_o}, {23'd0, e});

    for (int i = 0; i < 48; i++) begin
      r = $urandom();
      case ($urandom() % 4)
        0: w = r >> ($urandom() % 12);
        1: w = r / (($urandom() % 1920) + 1);
        2: w = (r >> ($urandom() % 10)) - ($urandom() % 1000);
        default: w = $urandom() % 2_000_000;
      endcase
      run(r, w, "R2 R4 random");
    end

    if (!dog) begin
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule